// File: doc/BRIEF.md
# Clock-Controlled Dual-LFSR Keystream Generator

This block produces a keystream of one bit per enabled clock from two linear feedback shift registers. A control register A advances once in every enabled cycle. Its most significant bit, taken before that advance, picks how many times a data register B is stepped in the same cycle. The keystream bit is then read from the most significant bit of the stepped B.

Two stepping variants are chosen at elaboration. In stop-and-go mode B either holds or steps once. In step-d/step-k mode B steps D or K times. All steps of one cycle are computed by an unrolled combinational chain, so throughput is a constant one bit per enabled clock. Both registers are seeded through a load port. A seed of all zeros is replaced by the value 1, so neither register can lock up.

Top module: `kg_clock_ctl_gen`

## Requirements
- R1: After reset, `ks_valid` and `ks_bit` are 0 and both A and B hold the value 1.
- R2: When `load` is high at a clock edge, A takes `seed_a` and B takes `seed_b`, and `ks_valid` is 0 in the following cycle.
- R3: An all-zero seed for either register is stored as the value 1.
- R4: In every cycle with `en` high and `load` low, A advances once. An advance shifts left by one and inserts at bit 0 the XOR of the state bits selected by the tap mask. The control bit is bit M-1 of A before this advance.
- R5: In stop-and-go mode, B holds its state when the control bit is 0 and advances once (same shift rule with its own mask) when it is 1.
- R6: In step-d/step-k mode, B advances D times when the control bit is 0 and K times when it is 1, with 0 <= D, K <= 4.
- R7: In an enabled cycle, `ks_bit` takes bit N-1 of B after its steps, registered at that clock edge.
- R8: `ks_valid` is high exactly in the cycle after an edge where `en` was high and `load` was low.
- R9: With `en` and `load` both low, A, B and `ks_bit` keep their values.
- R10: `load` takes priority over `en`: when both are high, the seeds are written and no keystream bit is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Write the seeds into both registers |
| seed_a | input | M | Seed for the control register |
| seed_b | input | N | Seed for the data register |
| en | input | 1 | Produce one keystream bit this cycle |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | `ks_bit` was produced in the last cycle |

## Verification
The bench runs a stop-and-go instance and a step-2/step-3 instance side by side against a bit-serial reference model. It goes after zero seeds: a design that stored them literally would emit constant zeros forever. It also drives `load` together with `en`; a design with the wrong priority would advance the fresh seed or raise the valid flag. Long idle stretches catch a design that keeps stepping or lets the output bit drift. Random control sequences catch a design that uses the control bit after A's advance, or swaps D and K, because either error makes the keystream diverge from the model within a few bits.

// File: rtl/kg_pkg.sv
package kg_pkg;
  typedef enum logic {
    MODE_STOP_GO = 1'b0,
    MODE_STEP_DK = 1'b1
  } step_mode_e;

  localparam int unsigned STEP_CNT_W = 3;
  localparam int unsigned STEP_MAX   = 4;
endpackage

// File: rtl/kg_lfsr_chain.sv
module kg_lfsr_chain #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] TAPS   = '1,
  parameter int unsigned MAXSTEP = 1
) (
  input  logic [W-1:0]                 s_in,
  input  logic [kg_pkg::STEP_CNT_W-1:0] steps,
  output logic [W-1:0]                 s_out
);
  function automatic logic [W-1:0] lfsr_adv(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  logic [W-1:0] chain [0:MAXSTEP];
  assign chain[0] = s_in;

  for (genvar i = 0; i < MAXSTEP; i++) begin : g_stage
    assign chain[i+1] = lfsr_adv(chain[i]);
  end

  always_comb begin
    s_out = chain[0];
    for (int j = 1; j <= MAXSTEP; j++) begin
      if (int'(steps) == j) s_out = chain[j];
    end
  end
endmodule

// File: rtl/kg_lfsr_reg.sv
module kg_lfsr_reg #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] TAPS   = '1,
  parameter int unsigned MAXSTEP = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [W-1:0]                 seed,
  input  logic                         adv,
  input  logic [kg_pkg::STEP_CNT_W-1:0] steps,
  output logic [W-1:0]                 q,
  output logic [W-1:0]                 q_next
);
  localparam logic [W-1:0] SAFE_SEED = W'(1);

  logic [W-1:0] seed_ok;
  assign seed_ok = (seed == '0) ? SAFE_SEED : seed;

  kg_lfsr_chain #(.W(W), .TAPS(TAPS), .MAXSTEP(MAXSTEP)) u_chain (
    .s_in  (q),
    .steps (steps),
    .s_out (q_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= SAFE_SEED;
    else if (load) q <= seed_ok;
    else if (adv)  q <= q_next;
  end
endmodule

// File: rtl/kg_clock_ctl_gen.sv
module kg_clock_ctl_gen #(
  parameter int unsigned M              = 7,
  parameter int unsigned N              = 11,
  parameter logic [M-1:0] TAPS_A        = 7'b1100000,
  parameter logic [N-1:0] TAPS_B        = 11'b10100000000,
  parameter kg_pkg::step_mode_e MODE    = kg_pkg::MODE_STEP_DK,
  parameter int unsigned D              = 2,
  parameter int unsigned K              = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [M-1:0] seed_a,
  input  logic [N-1:0] seed_b,
  input  logic         en,
  output logic         ks_bit,
  output logic         ks_valid
);
  import kg_pkg::*;

  localparam int unsigned D_EFF   = (MODE == MODE_STOP_GO) ? 0 : D;
  localparam int unsigned K_EFF   = (MODE == MODE_STOP_GO) ? 1 : K;
  localparam int unsigned B_MAX   = (D_EFF > K_EFF) ? D_EFF : K_EFF;
  localparam logic [STEP_CNT_W-1:0] CNT_D = STEP_CNT_W'(D_EFF);
  localparam logic [STEP_CNT_W-1:0] CNT_K = STEP_CNT_W'(K_EFF);

  // named internal events, visible to the checker
  logic                  adv;
  logic                  ctl_bit;
  logic [STEP_CNT_W-1:0] b_steps;
  logic [M-1:0]          a_q, a_next;
  logic [N-1:0]          b_q, b_next;

  assign adv     = en && !load;
  assign ctl_bit = a_q[M-1];
  assign b_steps = ctl_bit ? CNT_K : CNT_D;

  kg_lfsr_reg #(.W(M), .TAPS(TAPS_A), .MAXSTEP(1)) u_reg_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .seed   (seed_a),
    .adv    (adv),
    .steps  (STEP_CNT_W'(1)),
    .q      (a_q),
    .q_next (a_next)
  );

  kg_lfsr_reg #(.W(N), .TAPS(TAPS_B), .MAXSTEP(B_MAX)) u_reg_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .seed   (seed_b),
    .adv    (adv),
    .steps  (b_steps),
    .q      (b_q),
    .q_next (b_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
    end else begin
      ks_valid <= adv;
      if (adv) ks_bit <= b_next[N-1];
    end
  end
endmodule

// File: rtl/kg_checker.sv
module kg_checker #(
  parameter int unsigned M = 7,
  parameter int unsigned N = 11
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic         en,
  input logic [M-1:0] seed_a,
  input logic [N-1:0] seed_b,
  input logic         ks_bit,
  input logic         ks_valid,
  input logic [M-1:0] a_q,
  input logic [N-1:0] b_q,
  input logic [2:0]   b_steps
);
  a_r8_valid_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> ks_valid);
  a_r8_valid_low_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && !load) |=> !ks_valid);
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> ($stable(a_q) && $stable(b_q) && $stable(ks_bit)));
  a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (a_q != '0) && (b_q != '0));
  a_r2_seed_written: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed_a != '0 && seed_b != '0) |=> (a_q == $past(seed_a) && b_q == $past(seed_b)));
  a_r10_load_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ks_valid);
  a_r7_bit_is_b_msb: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid |-> (ks_bit == b_q[N-1]));
  a_r4_a_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> (a_q != $past(a_q)));
  a_r5_zero_steps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && b_steps == 3'd0) |=> $stable(b_q));
endmodule

bind kg_clock_ctl_gen kg_checker #(.M(M), .N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load     (load),
  .en       (en),
  .seed_a   (seed_a),
  .seed_b   (seed_b),
  .ks_bit   (ks_bit),
  .ks_valid (ks_valid),
  .a_q      (a_q),
  .b_q      (b_q),
  .b_steps  (b_steps)
);

// File: tb/sim_kg_clock_ctl_gen.sv
`timescale 1ns/1ps
module sim_kg_clock_ctl_gen;
  localparam int CLK_PERIOD = 10;
  localparam int M = 7;
  localparam int N = 11;
  localparam logic [31:0] TA = 32'h60;
  localparam logic [31:0] TB = 32'h500;
  localparam int GD = 2, GK = 3;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, en = 1'b0;
  logic [M-1:0] seed_a = '0;
  logic [N-1:0] seed_b = '0;
  logic ks0, kv0, ks1, kv1;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kg_clock_ctl_gen #(.M(M), .N(N), .MODE(kg_pkg::MODE_STEP_DK), .D(GD), .K(GK)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .seed_a(seed_a), .seed_b(seed_b),
    .en(en), .ks_bit(ks0), .ks_valid(kv0));
  kg_clock_ctl_gen #(.M(M), .N(N), .MODE(kg_pkg::MODE_STOP_GO)) u1 (
    .clk(clk), .rst_n(rst_n), .load(load), .seed_a(seed_a), .seed_b(seed_b),
    .en(en), .ks_bit(ks1), .ks_valid(kv1));

  // reference model state: [0] generalized, [1] stop-and-go
  logic [31:0] ma [2];
  logic [31:0] mb [2];
  logic        mks [2];
  logic        mkv [2];

  function automatic logic [31:0] ref_step(input logic [31:0] s, input logic [31:0] taps, input int w);
    logic fb = 1'b0;
    for (int i = 0; i < w; i++) if (taps[i]) fb = fb ^ s[i];
    ref_step = ((s << 1) | {31'd0, fb}) & ((32'd1 << w) - 1);
  endfunction

  task automatic model_edge(input logic ld, input logic e, input logic [31:0] sa, input logic [31:0] sb);
    for (int u = 0; u < 2; u++) begin
      if (ld) begin
        ma[u] = (sa == 0) ? 32'd1 : sa;
        mb[u] = (sb == 0) ? 32'd1 : sb;
        mkv[u] = 1'b0;
      end else if (e) begin
        logic c = ma[u][M-1];
        int n = (u == 0) ? (c ? GK : GD) : (c ? 1 : 0);
        ma[u] = ref_step(ma[u], TA, M);
        for (int s = 0; s < n; s++) mb[u] = ref_step(mb[u], TB, N);
        mks[u] = mb[u][N-1];
        mkv[u] = 1'b1;
      end else begin
        mkv[u] = 1'b0;
      end
    end
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic compare(input string tag0, input string tag1);
    check({tag0, "/R8 valid"}, kv0, mkv[0]);
    check({tag1, "/R8 valid"}, kv1, mkv[1]);
    check({tag0, " bit"}, ks0, mks[0]);
    check({tag1, " bit"}, ks1, mks[1]);
  endtask

  task automatic cycle(input logic ld, input logic e, input logic [M-1:0] sa, input logic [N-1:0] sb,
                       input string tag0, input string tag1);
    @(negedge clk);
    load = ld; en = e; seed_a = sa; seed_b = sb;
    @(posedge clk);
    model_edge(ld, e, 32'(sa), 32'(sb));
    #(CLK_PERIOD/4);
    compare(tag0, tag1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2015));
    for (int u = 0; u < 2; u++) begin ma[u] = 1; mb[u] = 1; mks[u] = 0; mkv[u] = 0; end
    #(CLK_PERIOD * 2 + 3);
    check("R1 valid u0", kv0, 1'b0); check("R1 bit u0", ks0, 1'b0);
    check("R1 valid u1", kv1, 1'b0); check("R1 bit u1", ks1, 1'b0);
    rst_n = 1'b1;
    // run from reset state 1/1
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, '0, '0, "R4 R6 R7", "R4 R5 R7");
    // directed seeds
    cycle(1'b1, 1'b0, 7'h55, 11'h2a3, "R2", "R2");
    for (int i = 0; i < 16; i++) cycle(1'b0, 1'b1, '0, '0, "R6", "R5");
    // zero seeds
    cycle(1'b1, 1'b0, '0, '0, "R3", "R3");
    for (int i = 0; i < 16; i++) cycle(1'b0, 1'b1, '0, '0, "R3 stream", "R3 stream");
    // idle stretch
    for (int i = 0; i < 8; i++) cycle(1'b0, 1'b0, 7'h11, 11'h7ff, "R9", "R9");
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, '0, '0, "R9 resume", "R9 resume");
    // load together with enable
    cycle(1'b1, 1'b1, 7'h40, 11'h400, "R10", "R10");
    for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, '0, '0, "R10 after", "R10 after");
    cycle(1'b1, 1'b1, '0, 11'h001, "R10 R3", "R10 R3");
    for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, '0, '0, "R3 R10", "R3 R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic ld = ($urandom_range(0, 99) < 3);
      logic e  = ($urandom_range(0, 99) < 80);
      logic [M-1:0] sa = ($urandom_range(0, 7) == 0) ? '0 : M'($urandom);
      logic [N-1:0] sb = ($urandom_range(0, 7) == 0) ? '0 : N'($urandom);
      if (ld) cycle(ld, e, sa, sb, "R2 rnd", "R2 rnd");
      else if (!e) cycle(ld, e, sa, sb, "R9 rnd", "R9 rnd");
      else cycle(ld, e, sa, sb, "R6 rnd", "R5 rnd");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule